// File: doc/BRIEF.md
# Byte-Queued SPI Master with Register Access

This block is an SPI master that a processor drives through a 32-bit register window. Software queues bytes by writing a transmit-data register. A shift engine sends each queued byte on `sclk`/`mosi` in SPI mode 0, MSB first. For every byte sent, the engine captures one byte from `miso` into a receive queue. Software drains that queue through a receive-data register. Each queue holds `FIFO_DEPTH` bytes.

A control bit called "hold" keeps queued bytes in the transmit queue until software clears it. Once the bit is cleared, the engine sends every queued byte back to back. Other registers cover:
- two self-clearing queue-flush bits,
- a read-only status word,
- a select register that drives active-low chip selects directly,
- occupancy readouts,
- a keyed whole-block reset.

Four event lines go to an external interrupt collector: receive-not-empty, receive-full, overrun and byte-done.

The shift engine is a four-state machine:
- **ST_IDLE** moves to **ST_LOW** when a byte is queued and hold is clear (transition *launch*, which pops the byte).
- **ST_LOW** moves to **ST_HIGH** after `CLK_DIV` cycles (transition *rise*, which samples `miso`).
- **ST_HIGH** moves back to **ST_LOW** after `CLK_DIV` cycles while bits remain (transition *fall*, which shifts). After the eighth bit it moves to **ST_DONE** instead (transition *last*).
- **ST_DONE** always returns to **ST_IDLE** (transition *retire*). On the way it stores the received byte, or drops it when the receive queue is full.

Top module: `spi_fifo_master`

## Requirements
- R1: Register byte offsets are:

  | Offset | Register |
  |--------|----------|
  | 0x40 | key reset |
  | 0x60 | control |
  | 0x64 | status |
  | 0x68 | transmit data |
  | 0x6C | receive data |
  | 0x70 | select |
  | 0x74 | transmit occupancy |
  | 0x78 | receive occupancy |

  Reads return data combinationally in the cycle `bus_rd`/`bus_addr` are presented. Unmapped offsets read 0.
- R2: A write of exactly 0x0000000A to offset 0x40 restores the whole block to its reset state. Any other value written there changes nothing.
- R3: Control bit 8 (hold) resets to 1. While it is 1, queued bytes stay queued and `sclk` does not toggle. Control reads back as bit 8 only.
- R4: Writing control bit 5 as 1 empties the transmit queue, and writing bit 6 as 1 empties the receive queue. Both bits read back as 0.
- R5: Status layout: bit 3 is transmit full, bit 2 is transmit empty, bit 1 is receive full, bit 0 is receive empty, and the upper bits are 0. Writes to status are ignored. The value after reset is 0x5.
- R6: When a byte completes while the receive queue is full, that byte is discarded and `ev_rx_overrun` pulses for one cycle.
- R7: With hold clear, the engine sends every queued byte until the transmit queue is empty. `ev_byte_done` pulses for one cycle per completed byte. Each received byte is stored in arrival order.
- R8: Reading receive data while the receive queue is empty returns 0xDEADBEEF and removes nothing.
- R9: The select register resets to all ones. `cs_n[i]` equals bit i of that register.
- R10: Transfers use SPI mode 0, MSB first. `sclk` idles low and stays high for `CLK_DIV` system cycles per bit, which gives 8*`CLK_DIV` high cycles per byte. `miso` is sampled at each rising edge.
- R11: An occupancy register reads the entry count minus one, or 0 when its queue is empty.
- R12: A transmit-data write while the transmit queue is full is dropped.
- R13: Each queue holds exactly `FIFO_DEPTH` bytes. After `FIFO_DEPTH` transfers with no reads, status reads 0x6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive data) |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NUM_CS | Active-low chip selects |
| ev_rx_not_empty | output | 1 | Receive queue holds data (level) |
| ev_rx_full | output | 1 | Receive queue full (level) |
| ev_rx_overrun | output | 1 | Received byte discarded (pulse) |
| ev_byte_done | output | 1 | One byte finished shifting (pulse) |

## Verification
The serial path is tried in two ways:
- **Random batches** of 1 to 12 bytes, queued under hold and then released. A bench-side receiver logs `mosi` at each rising `sclk`. An inverting loopback returns the complement on `miso`. Together these separate bit-order errors, sampling-edge errors and byte-order errors in the receive queue. Counting `sclk` high cycles per batch checks the divider.
- **A directed saturation pattern**, which fills the transmit queue to the brim plus one extra byte. It drains into a full receive queue, then sends one more byte. This separates the drop-on-full rule for transmit writes from the discard-and-flag rule on receive.

Short directed sequences cover the remaining rules:
- key-reset values, both accepted and ignored;
- the flush bits;
- the empty-read marker.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_DONE
    } xfer_state_t;

    localparam logic [7:0] OFS_KEYRST = 8'h40;
    localparam logic [7:0] OFS_CTRL   = 8'h60;
    localparam logic [7:0] OFS_STAT   = 8'h64;
    localparam logic [7:0] OFS_TXD    = 8'h68;
    localparam logic [7:0] OFS_RXD    = 8'h6C;
    localparam logic [7:0] OFS_SEL    = 8'h70;
    localparam logic [7:0] OFS_TXOCC  = 8'h74;
    localparam logic [7:0] OFS_RXOCC  = 8'h78;

    localparam logic [31:0] RESET_KEY  = 32'h0000_000A;
    localparam logic [31:0] EMPTY_MARK = 32'hDEAD_BEEF;

    localparam int HOLD_BIT   = 8;
    localparam int TXCLR_BIT  = 5;
    localparam int RXCLR_BIT  = 6;

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int DEPTH = 256,
    parameter int WIDTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic             do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            end
            if (do_pop) begin
                rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_master_pkg::*;
#(
    parameter int CLK_DIV = 2,
    localparam int DW     = $clog2(CLK_DIV + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        start_ok,
    input  logic [7:0]  tx_byte,
    input  logic        miso,
    output logic        tx_pop,
    output logic        rx_push,
    output logic [7:0]  rx_byte,
    output logic        sclk,
    output logic        mosi,
    output xfer_state_t state_o
);

    xfer_state_t state, next;
    logic [DW-1:0] div_cnt;
    logic [2:0]    bit_cnt;
    logic [7:0]    shreg;
    logic          rx_bit;
    logic          half_end;

    assign half_end = (div_cnt == DW'(CLK_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else if (clr) begin
            state <= ST_IDLE;
        end else begin
            state <= next;
        end
    end

    always_comb begin
        next = state;
        unique case (state)
            ST_IDLE: if (start_ok) next = ST_LOW;
            ST_LOW:  if (half_end) next = ST_HIGH;
            ST_HIGH: if (half_end) next = (bit_cnt == 3'd7) ? ST_DONE : ST_LOW;
            ST_DONE: next = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
            bit_cnt <= '0;
            shreg   <= '0;
            rx_bit  <= 1'b0;
        end else if (clr) begin
            div_cnt <= '0;
            bit_cnt <= '0;
            shreg   <= '0;
            rx_bit  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_ok) begin
                        shreg   <= tx_byte;
                        div_cnt <= '0;
                        bit_cnt <= '0;
                    end
                end
                ST_LOW: begin
                    if (half_end) begin
                        div_cnt <= '0;
                        rx_bit  <= miso;
                    end else begin
                        div_cnt <= div_cnt + 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (half_end) begin
                        div_cnt <= '0;
                        shreg   <= {shreg[6:0], rx_bit};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else begin
                        div_cnt <= div_cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        tx_pop  = (state == ST_IDLE) && start_ok;
        rx_push = (state == ST_DONE);
        rx_byte = shreg;
        sclk    = (state == ST_HIGH);
        mosi    = (state == ST_IDLE) ? 1'b0 : shreg[7];
        state_o = state;
    end

endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
    import spi_master_pkg::*;
#(
    parameter int FIFO_DEPTH = 256,
    parameter int NUM_CS     = 2,
    parameter int CLK_DIV    = 2,
    localparam int CW        = $clog2(FIFO_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_n,
    output logic              ev_rx_not_empty,
    output logic              ev_rx_full,
    output logic              ev_rx_overrun,
    output logic              ev_byte_done
);

    logic              key_rst, ctrl_wr, tx_clr, rx_clr;
    logic              inhibit_q;
    logic [NUM_CS-1:0] sel_q;
    logic              tx_push, tx_pop, tx_full, tx_empty;
    logic              rx_push, rx_pop, rx_full, rx_empty;
    logic [7:0]        tx_dout, rx_dout, eng_rx_byte;
    logic [CW-1:0]     tx_count, rx_count;
    xfer_state_t       eng_state;

    function automatic logic [31:0] occ_value(input logic [CW-1:0] n);
        return (n == '0) ? 32'd0 : 32'(n - 1'b1);
    endfunction

    assign key_rst = bus_wr && (bus_addr == OFS_KEYRST) && (bus_wdata == RESET_KEY);
    assign ctrl_wr = bus_wr && (bus_addr == OFS_CTRL);
    assign tx_clr  = key_rst || (ctrl_wr && bus_wdata[TXCLR_BIT]);
    assign rx_clr  = key_rst || (ctrl_wr && bus_wdata[RXCLR_BIT]);
    assign tx_push = bus_wr && (bus_addr == OFS_TXD);
    assign rx_pop  = bus_rd && (bus_addr == OFS_RXD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inhibit_q <= 1'b1;
            sel_q     <= '1;
        end else if (key_rst) begin
            inhibit_q <= 1'b1;
            sel_q     <= '1;
        end else begin
            if (ctrl_wr) begin
                inhibit_q <= bus_wdata[HOLD_BIT];
            end
            if (bus_wr && (bus_addr == OFS_SEL)) begin
                sel_q <= bus_wdata[NUM_CS-1:0];
            end
        end
    end

    byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr),
        .push(tx_push), .din(bus_wdata[7:0]), .pop(tx_pop), .dout(tx_dout),
        .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr),
        .push(rx_push), .din(eng_rx_byte), .pop(rx_pop), .dout(rx_dout),
        .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    spi_shift_engine #(.CLK_DIV(CLK_DIV)) u_engine (
        .clk(clk), .rst_n(rst_n), .clr(key_rst),
        .start_ok(!inhibit_q && !tx_empty), .tx_byte(tx_dout), .miso(miso),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_byte(eng_rx_byte),
        .sclk(sclk), .mosi(mosi), .state_o(eng_state)
    );

    for (genvar g = 0; g < NUM_CS; g++) begin : g_sel
        assign cs_n[g] = sel_q[g];
    end

    assign ev_rx_not_empty = !rx_empty;
    assign ev_rx_full      = rx_full;
    assign ev_rx_overrun   = rx_push && rx_full;
    assign ev_byte_done    = rx_push;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL:  bus_rdata[HOLD_BIT] = inhibit_q;
            OFS_STAT:  bus_rdata = {28'd0, tx_full, tx_empty, rx_full, rx_empty};
            OFS_RXD:   bus_rdata = rx_empty ? EMPTY_MARK : {24'd0, rx_dout};
            OFS_SEL:   bus_rdata = 32'(sel_q);
            OFS_TXOCC: bus_rdata = occ_value(tx_count);
            OFS_RXOCC: bus_rdata = occ_value(rx_count);
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk
    import spi_master_pkg::*;
#(
    parameter int FIFO_DEPTH = 256,
    parameter int NUM_CS     = 2,
    localparam int CW        = $clog2(FIFO_DEPTH) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [7:0]        bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [NUM_CS-1:0] cs_n,
    input logic              ev_rx_overrun,
    input logic              ev_rx_full,
    input logic              ev_byte_done,
    input logic              inhibit_q,
    input xfer_state_t       eng_state,
    input logic              tx_full,
    input logic              tx_pop,
    input logic [CW-1:0]     tx_count
);

    AST_KEY_RESTORES_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_KEYRST && bus_wdata == RESET_KEY) |=> (&cs_n)); // R2

    AST_HOLD_KEEPS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit_q && eng_state == ST_IDLE) |=> (eng_state == ST_IDLE)); // R3

    AST_OVERRUN_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_overrun |-> ev_rx_full); // R6

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_byte_done |=> !ev_byte_done); // R7

    AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && bus_wr && bus_addr == OFS_TXD && !tx_pop) |=> (tx_count == CW'(FIFO_DEPTH))); // R12

endmodule

bind spi_fifo_master spi_fifo_master_chk #(.FIFO_DEPTH(FIFO_DEPTH), .NUM_CS(NUM_CS)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .cs_n(cs_n), .ev_rx_overrun(ev_rx_overrun), .ev_rx_full(ev_rx_full),
    .ev_byte_done(ev_byte_done), .inhibit_q(inhibit_q), .eng_state(eng_state),
    .tx_full(tx_full), .tx_pop(tx_pop), .tx_count(tx_count)
);

// File: tb/tb_spi_fifo_master.sv
module tb_spi_fifo_master;
    import spi_master_pkg::*;

    localparam int DEPTH = 256;
    localparam int NCS   = 2;
    localparam int DIV   = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]     bus_addr = '0;
    logic [31:0]    bus_wdata = '0, bus_rdata;
    logic           sclk, mosi, miso;
    logic [NCS-1:0] cs_n;
    logic           ev_rx_not_empty, ev_rx_full, ev_rx_overrun, ev_byte_done;

    spi_fifo_master #(.FIFO_DEPTH(DEPTH), .NUM_CS(NCS), .CLK_DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n),
        .ev_rx_not_empty(ev_rx_not_empty), .ev_rx_full(ev_rx_full),
        .ev_rx_overrun(ev_rx_overrun), .ev_byte_done(ev_byte_done)
    );

    always #10 clk = ~clk;
    assign miso = ~mosi;

    int n_chk = 0, n_fail = 0;
    int done_cnt = 0, ovr_cnt = 0, sclk_hi = 0;
    bit reported = 0;
    logic [7:0] line_sh = '0;
    int line_bits = 0;
    logic [7:0] line_q[$];

    always @(negedge clk) begin
        if (ev_byte_done) done_cnt++;
        if (ev_rx_overrun) ovr_cnt++;
        if (sclk) sclk_hi++;
    end

    always @(posedge sclk) begin
        line_sh = {line_sh[6:0], mosi};
        line_bits++;
        if (line_bits == 8) begin
            line_q.push_back(line_sh);
            line_bits = 0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_done(input int target);
        while (done_cnt < target) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [31:0] exp_occ(input int n);
        return (n == 0) ? 32'd0 : 32'(n - 1);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  bytes[$];
        int base, hi0, bad;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        rd(OFS_CTRL, v);  check("R3 hold set after reset", v, 32'h100);
        rd(OFS_STAT, v);  check("R5 status after reset", v, 32'h5);
        check("R9 selects after reset", 32'(cs_n), 32'h3);
        rd(OFS_TXOCC, v); check("R11 tx occupancy empty", v, 32'h0);
        check("R10 sclk idles low", 32'(sclk), 32'h0);
        rd(8'h7C, v);     check("R1 unmapped offset reads zero", v, 32'h0);

        // status is read-only
        wr(OFS_STAT, 32'hF);
        rd(OFS_STAT, v);  check("R5 status ignores writes", v, 32'h5);

        // select lines
        wr(OFS_SEL, 32'h1);
        check("R9 cs_n follows select", 32'(cs_n), 32'h1);
        rd(OFS_SEL, v);   check("R1 select readback", v, 32'h1);

        // keyed reset
        wr(OFS_KEYRST, 32'h5);
        check("R2 wrong key ignored", 32'(cs_n), 32'h1);
        wr(OFS_CTRL, 32'h0);
        wr(OFS_KEYRST, 32'hA);
        check("R2 key restores selects", 32'(cs_n), 32'h3);
        rd(OFS_CTRL, v);  check("R2 key restores hold", v, 32'h100);

        // empty read
        rd(OFS_RXD, v);   check("R8 empty read marker", v, EMPTY_MARK);
        rd(OFS_STAT, v);  check("R8 empty read pops nothing", v, 32'h5);

        // random batches
        for (int r = 0; r < 5; r++) begin
            int n = $urandom_range(1, 12);
            bytes.delete();
            line_q.delete();
            for (int i = 0; i < n; i++) begin
                logic [7:0] b = 8'($urandom);
                bytes.push_back(b);
                wr(OFS_TXD, {24'd0, b});
            end
            rd(OFS_TXOCC, v); check("R11 tx occupancy n-1", v, exp_occ(n));
            base = done_cnt; hi0 = sclk_hi;
            repeat (40) @(negedge clk);
            check("R3 hold keeps bytes queued", 32'(done_cnt - base), 32'd0);
            check("R3 no sclk under hold", 32'(sclk_hi - hi0), 32'd0);
            wr(OFS_CTRL, 32'h0);
            wait_done(base + n);
            check("R10 sclk high cycles per batch", 32'(sclk_hi - hi0), 32'(n * 8 * DIV));
            rd(OFS_STAT, v);  check("R7 tx drained", 32'(v[2]), 32'h1);
            rd(OFS_RXOCC, v); check("R11 rx occupancy n-1", v, exp_occ(n));
            bad = 0;
            for (int i = 0; i < n; i++) begin
                rd(OFS_RXD, v);
                if (v !== {24'd0, ~bytes[i]}) bad++;
                if (line_q.size() <= i || line_q[i] !== bytes[i]) bad++;
            end
            check("R7 R10 received and shifted bytes in order", 32'(bad), 32'd0);
            wr(OFS_CTRL, 32'h100);
        end

        // flush bits
        for (int i = 0; i < 3; i++) wr(OFS_TXD, 32'(i));
        wr(OFS_CTRL, 32'h120);
        rd(OFS_STAT, v);  check("R4 tx flush empties queue", v, 32'h5);
        rd(OFS_CTRL, v);  check("R4 flush bits read zero", v, 32'h100);
        base = done_cnt;
        wr(OFS_TXD, 32'h11);
        wr(OFS_TXD, 32'h22);
        wr(OFS_CTRL, 32'h0);
        wait_done(base + 2);
        wr(OFS_CTRL, 32'h140);
        rd(OFS_RXOCC, v); check("R4 rx flush occupancy", v, 32'h0);
        rd(OFS_STAT, v);  check("R4 rx flush status", v, 32'h5);

        // saturation
        line_q.delete();
        for (int i = 0; i < DEPTH; i++) wr(OFS_TXD, 32'(i & 8'hFF));
        rd(OFS_STAT, v);  check("R13 tx full after depth writes", v, 32'h9);
        wr(OFS_TXD, 32'hEE);
        rd(OFS_TXOCC, v); check("R12 write to full tx dropped", v, 32'(DEPTH - 1));
        base = done_cnt;
        wr(OFS_CTRL, 32'h0);
        wait_done(base + DEPTH);
        rd(OFS_STAT, v);  check("R13 rx full tx empty", v, 32'h6);
        check("R6 no overrun before excess", 32'(ovr_cnt), 32'd0);
        wr(OFS_TXD, 32'h77);
        wait_done(base + DEPTH + 1);
        check("R6 overrun flagged once", 32'(ovr_cnt), 32'd1);
        rd(OFS_RXOCC, v); check("R6 excess byte discarded", v, 32'(DEPTH - 1));
        bad = 0;
        for (int i = 0; i < DEPTH; i++) begin
            rd(OFS_RXD, v);
            if (v !== {24'd0, ~8'(i)}) bad++;
        end
        check("R7 R13 full queue contents", 32'(bad), 32'd0);
        rd(OFS_RXD, v);   check("R8 drained queue marker", v, EMPTY_MARK);

        report();
        $finish;
    end

endmodule